// File: doc/BRIEF.md
# Single-Source Interrupt Status Unit

This block keeps the interrupt state for one source, a timer that signals its events with single-cycle pulses. A latched raw flag records every event whether or not the source is enabled. A mask bit decides whether that flag reaches the level interrupt line and the masked view. Software reaches the state through a small register window. It can read the raw and masked views, raise the flag on purpose for diagnostics, and drop it with a write-one-to-clear.

An index register gives a fast handler entry. It reads as 1 while the timer source is pending and unmasked, and as 0 otherwise. A read that returns 1 also consumes the flag, so a handler does not need a separate clear. A 2-bit mode field is read-only and always reports that software is responsible for clearing the flag.

The register port is a simple strobe interface. `reg_wr` or `reg_rd` is held for one cycle together with a word address. Read data is combinational from the current state. Any state change caused by the access takes effect at the clock edge that ends the access.

Top module: `irq_stat_unit`

## Requirements
- R1: After reset the raw flag and the mask are 0, `irq_o` is 0, and the index reads 0.
- R2: An `evt_pulse` sets the raw flag at the next clock edge, whatever the mask holds. The raw view is at address 1, bit 0.
- R3: The masked view at address 2, bit 0, reads as the raw flag AND the mask bit. The mask is address 0, bit 0, and is read/write.
- R4: A write to address 3 with data bit 0 at 1 sets the raw flag. The same write with bit 0 at 0 leaves the flag unchanged.
- R5: A write to address 4 with data bit 0 at 1 clears the raw flag, also while the mask is 0. The same write with bit 0 at 0 leaves the flag unchanged.
- R6: The index at address 5 reads 1 when the flag is set and unmasked, and 0 otherwise. A read that returns 1 clears the raw flag. A read that returns 0 leaves the flag unchanged.
- R7: Address 6 reads the mode value 1 in bits 1:0. Writes to it change nothing.
- R8: If an event arrives in the same cycle as a clear write or a consuming index read, the raw flag ends up set.
- R9: `irq_o` equals the masked status of the previous cycle. It is a registered copy and lags the flag by one clock.
- R10: Unmapped addresses and all unused upper data bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 1 | One-cycle event from the timer |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (4) | Word address of the access |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data, valid while `reg_rd` is high |
| irq_o | output | 1 | Level interrupt, registered masked status |

## Verification
The bench builds the unit with its defaults: a 32-bit data word and a 4-bit address. With a 4-bit address, the nine unmapped addresses from 7 to 15 can be read. With a 32-bit word, the zero upper bits of every readable register can be compared as full words. At these widths the vector table can place an event in the same cycle as a clear write and as a consuming index read. It also covers masked index reads that must not consume the flag, and the one-cycle lag of the interrupt line.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

  // Word addresses of the register window
  typedef enum logic [2:0] {
    OFS_MASK = 3'd0,
    OFS_RAW  = 3'd1,
    OFS_MSKD = 3'd2,
    OFS_SET  = 3'd3,
    OFS_CLR  = 3'd4,
    OFS_IDX  = 3'd5,
    OFS_MODE = 3'd6
  } reg_ofs_e;

  localparam int unsigned NUM_REGS = 7;

  // Index codes
  localparam int unsigned IDX_NONE  = 0;
  localparam int unsigned IDX_TIMER = 1;

  // Mode field: software-clear
  localparam int unsigned MODE_SWCLR = 1;

  typedef struct packed {
    logic mask_we;
    logic set_hit;
    logic clr_hit;
    logic idx_rd;
  } reg_strobe_t;

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_stat_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                wbit,
  output reg_strobe_t         strb,
  output logic [NUM_REGS-1:0] rd_sel
);

  logic [NUM_REGS-1:0] hit;

  // One comparator per register
  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
      assign hit[g] = (reg_addr == ADDR_W'(g));
    end
  endgenerate

  always_comb begin
    strb.mask_we = reg_wr & hit[OFS_MASK];
    strb.set_hit = reg_wr & hit[OFS_SET] & wbit;
    strb.clr_hit = reg_wr & hit[OFS_CLR] & wbit;
    strb.idx_rd  = reg_rd & hit[OFS_IDX];
  end

  assign rd_sel = reg_rd ? hit : '0;

endmodule

// File: rtl/irq_flag_core.sv
module irq_flag_core
  import irq_stat_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        evt_pulse,
  input  reg_strobe_t strb,
  input  logic        wbit,
  output logic        raw_q,
  output logic        mask_q,
  output logic        irq_q
);

  logic raw_d, raw_en;
  logic mask_d, mask_en;
  logic irq_d;
  logic set_req, clr_req;

  // Next-state logic; a set request overrides a clear request
  always_comb begin
    set_req = evt_pulse | strb.set_hit;
    clr_req = strb.clr_hit | (strb.idx_rd & raw_q & mask_q);
    raw_en  = set_req | clr_req;
    raw_d   = set_req;
    mask_en = strb.mask_we;
    mask_d  = wbit;
    irq_d   = raw_q & mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= 1'b0;
      mask_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (raw_en)  raw_q  <= raw_d;
      if (mask_en) mask_q <= mask_d;
      irq_q <= irq_d;
    end
  end

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_stat_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned MODE_W = 2
) (
  input  logic [NUM_REGS-1:0] rd_sel,
  input  logic                raw_q,
  input  logic                mask_q,
  output logic [DATA_W-1:0]   rdata
);

  logic              mskd;
  logic [IDX_W-1:0]  idx_val;
  logic [MODE_W-1:0] mode_val;

  assign mskd     = raw_q & mask_q;
  assign idx_val  = mskd ? IDX_W'(IDX_TIMER) : IDX_W'(IDX_NONE);
  assign mode_val = MODE_W'(MODE_SWCLR);

  always_comb begin
    rdata = '0;
    if (rd_sel[OFS_MASK]) rdata[0] = mask_q;
    if (rd_sel[OFS_RAW])  rdata[0] = raw_q;
    if (rd_sel[OFS_MSKD]) rdata[0] = mskd;
    if (rd_sel[OFS_IDX])  rdata[IDX_W-1:0]  = idx_val;
    if (rd_sel[OFS_MODE]) rdata[MODE_W-1:0] = mode_val;
  end

endmodule

// File: rtl/irq_stat_unit.sv
module irq_stat_unit
  import irq_stat_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_pulse,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);

  reg_strobe_t         strb;
  logic [NUM_REGS-1:0] rd_sel;
  logic                raw_q;
  logic                mask_q;

  irq_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .reg_wr  (reg_wr),
    .reg_rd  (reg_rd),
    .reg_addr(reg_addr),
    .wbit    (reg_wdata[0]),
    .strb    (strb),
    .rd_sel  (rd_sel)
  );

  irq_flag_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_pulse(evt_pulse),
    .strb     (strb),
    .wbit     (reg_wdata[0]),
    .raw_q    (raw_q),
    .mask_q   (mask_q),
    .irq_q    (irq_o)
  );

  irq_read_mux #(.DATA_W(DATA_W), .IDX_W(IDX_W), .MODE_W(MODE_W)) u_rmux (
    .rd_sel(rd_sel),
    .raw_q (raw_q),
    .mask_q(mask_q),
    .rdata (reg_rdata)
  );

endmodule

// File: rtl/irq_stat_chk.sv
module irq_stat_chk
  import irq_stat_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_pulse,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq_o,
  input logic              raw_q,
  input logic              mask_q
);

  logic set_w, clr_w, idx_r, mode_r, mskd_r;
  assign set_w  = reg_wr && reg_addr == ADDR_W'(OFS_SET) && reg_wdata[0];
  assign clr_w  = reg_wr && reg_addr == ADDR_W'(OFS_CLR) && reg_wdata[0];
  assign idx_r  = reg_rd && reg_addr == ADDR_W'(OFS_IDX);
  assign mode_r = reg_rd && reg_addr == ADDR_W'(OFS_MODE);
  assign mskd_r = reg_rd && reg_addr == ADDR_W'(OFS_MSKD);

  AST_EVT_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |=> raw_q); // R2
  AST_MSKD_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
    mskd_r |-> reg_rdata[0] == (raw_q && mask_q)); // R3
  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    set_w |=> raw_q); // R4
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w && !evt_pulse && !set_w) |=> !raw_q); // R5
  AST_IDX_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_r && reg_rdata[0] && !evt_pulse && !set_w) |=> !raw_q); // R6
  AST_IDX_HIDES_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_r && !mask_q) |-> reg_rdata == '0); // R6
  AST_MODE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    mode_r |-> reg_rdata == DATA_W'(MODE_SWCLR)); // R7
  AST_EVT_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse && (clr_w || idx_r)) |=> raw_q); // R8
  AST_IRQ_LAGS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_o == ($past(raw_q) && $past(mask_q))); // R9

endmodule

bind irq_stat_unit irq_stat_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .evt_pulse(evt_pulse),
  .reg_wr   (reg_wr),
  .reg_rd   (reg_rd),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata),
  .irq_o    (irq_o),
  .raw_q    (raw_q),
  .mask_q   (mask_q)
);

// File: tb/irq_stat_unit_bench.sv
module irq_stat_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  localparam logic [1:0] OP_NOP = 2'd0;
  localparam logic [1:0] OP_WR  = 2'd1;
  localparam logic [1:0] OP_RD  = 2'd2;

  // {req[3:0], evt, op[1:0], addr[3:0], wbit, exp[4:0]}
  localparam int NV = 28;
  localparam logic [16:0] VEC [NV] = '{
    {4'd1, 1'b0, OP_RD, 4'd1, 1'b0, 5'd0},  // R1 raw 0
    {4'd1, 1'b0, OP_RD, 4'd5, 1'b0, 5'd0},  // R1 index 0
    {4'd7, 1'b0, OP_RD, 4'd6, 1'b0, 5'd1},  // R7 mode
    {4'd2, 1'b1, OP_RD, 4'd1, 1'b0, 5'd0},  // R2 event, old value seen
    {4'd2, 1'b0, OP_RD, 4'd1, 1'b0, 5'd1},  // R2 raw set while masked
    {4'd3, 1'b0, OP_RD, 4'd2, 1'b0, 5'd0},  // R3 masked view 0
    {4'd6, 1'b0, OP_RD, 4'd5, 1'b0, 5'd0},  // R6 masked index 0
    {4'd6, 1'b0, OP_RD, 4'd1, 1'b0, 5'd1},  // R6 not consumed
    {4'd3, 1'b0, OP_WR, 4'd0, 1'b1, 5'd0},  // R3 unmask
    {4'd3, 1'b0, OP_RD, 4'd2, 1'b0, 5'd1},  // R3 masked view 1
    {4'd6, 1'b0, OP_RD, 4'd5, 1'b0, 5'd1},  // R6 index 1, consumes
    {4'd6, 1'b0, OP_RD, 4'd1, 1'b0, 5'd0},  // R6 consumed
    {4'd4, 1'b0, OP_WR, 4'd3, 1'b0, 5'd0},  // R4 set with 0
    {4'd4, 1'b0, OP_RD, 4'd1, 1'b0, 5'd0},  // R4 no effect
    {4'd4, 1'b0, OP_WR, 4'd3, 1'b1, 5'd0},  // R4 set with 1
    {4'd4, 1'b0, OP_RD, 4'd2, 1'b0, 5'd1},  // R4 masked view follows
    {4'd5, 1'b0, OP_WR, 4'd0, 1'b0, 5'd0},  // R5 mask off
    {4'd5, 1'b0, OP_WR, 4'd4, 1'b1, 5'd0},  // R5 clear while masked
    {4'd5, 1'b0, OP_RD, 4'd1, 1'b0, 5'd0},  // R5 cleared
    {4'd7, 1'b0, OP_WR, 4'd6, 1'b0, 5'd0},  // R7 write mode
    {4'd7, 1'b0, OP_RD, 4'd6, 1'b0, 5'd1},  // R7 unchanged
    {4'd8, 1'b1, OP_WR, 4'd4, 1'b1, 5'd0},  // R8 event + clear
    {4'd8, 1'b0, OP_RD, 4'd1, 1'b0, 5'd1},  // R8 event won
    {4'd5, 1'b0, OP_WR, 4'd4, 1'b0, 5'd0},  // R5 clear with 0
    {4'd5, 1'b0, OP_RD, 4'd1, 1'b0, 5'd1},  // R5 no effect
    {4'd8, 1'b0, OP_WR, 4'd0, 1'b1, 5'd0},  // R8 unmask
    {4'd8, 1'b1, OP_RD, 4'd5, 1'b0, 5'd1},  // R8 event + consuming read
    {4'd8, 1'b0, OP_RD, 4'd1, 1'b0, 5'd1}   // R8 event won
  };

  logic              clk;
  logic              rst_n;
  logic              evt_pulse;
  logic              reg_wr;
  logic              reg_rd;
  logic [ADDR_W-1:0] reg_addr;
  logic [DATA_W-1:0] reg_wdata;
  logic [DATA_W-1:0] reg_rdata;
  logic              irq_o;

  int n_chk;
  int n_bad;
  bit done;

  irq_stat_unit #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_irq_stat_unit (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_pulse(evt_pulse),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .irq_o    (irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, settle, return before the rising edge
  task automatic drive(logic e, logic [1:0] op, logic [3:0] a, logic wb);
    @(negedge clk);
    evt_pulse = e;
    reg_wr    = (op == OP_WR);
    reg_rd    = (op == OP_RD);
    reg_addr  = a;
    reg_wdata = {{(DATA_W-1){1'b1}}, wb};
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    evt_pulse = 1'b0;
    reg_wr = 1'b0;
    reg_rd = 1'b0;
    reg_addr = '0;
    reg_wdata = '0;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    done = 1'b0;
    evt_pulse = 1'b0;
    reg_wr = 1'b0;
    reg_rd = 1'b0;
    reg_addr = '0;
    reg_wdata = '0;
    rst_n = 1'b0;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1", {31'd0, irq_o}, 32'd0);
    drive(1'b0, OP_RD, 4'd0, 1'b0);
    check("R1", reg_rdata, 32'd0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][12], VEC[i][11:10], VEC[i][9:6], VEC[i][5]);
      if (VEC[i][11:10] == OP_RD) begin
        n_chk++;
        if (reg_rdata !== DATA_W'(VEC[i][4:0])) begin
          n_bad++;
          $display("FAIL R%0d (vector %0d): got %0h expected %0h",
                   VEC[i][16:13], i, reg_rdata, VEC[i][4:0]);
        end
      end
    end
    // state now: raw 1, mask 1

    // R10 unmapped addresses and upper bits
    for (int a = 7; a < 16; a++) begin
      drive(1'b0, OP_RD, 4'(a), 1'b0);
      check("R10", reg_rdata, 32'd0);
    end
    drive(1'b0, OP_RD, 4'd1, 1'b0);
    check("R10", reg_rdata, 32'd1);

    // R9 interrupt lag
    idle();
    check("R9", {31'd0, irq_o}, 32'd1);
    drive(1'b0, OP_WR, 4'd4, 1'b1);   // clear at next edge
    idle();                            // raw now 0, irq still last value
    check("R9", {31'd0, irq_o}, 32'd1);
    idle();
    check("R9", {31'd0, irq_o}, 32'd0);
    drive(1'b1, OP_NOP, 4'd0, 1'b0);   // event
    idle();                            // raw 1, irq still 0
    check("R9", {31'd0, irq_o}, 32'd0);
    idle();
    check("R9", {31'd0, irq_o}, 32'd1);

    // R1 reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", {31'd0, irq_o}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b0, OP_RD, 4'd0, 1'b0);
    check("R1", reg_rdata, 32'd0);
    drive(1'b0, OP_RD, 4'd1, 1'b0);
    check("R1", reg_rdata, 32'd0);
    idle();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule